// File: doc/BRIEF.md
# Cascadable LCD Column Data Loader

This block loads one display line into a column driver that can be chained with identical drivers. Pixel data comes in on a parallel bus that is 8 or 12 bits wide. It is sampled on the falling edge of the shift clock and gathered into 24-bit groups. Each complete group is written into a holding register of `COLS` bits. A fill-direction input decides whether the columns fill from the first column upward or from the last column downward.

Every device in a chain waits for an active-low enable token after each line-latch pulse. Once it has the token, it takes exactly `COLS` bits. It then passes a one-cycle token to the next device and ignores all further bus words until the next latch pulse. The falling edge of the latch pulse copies the whole holding register into the output row at once. A 2-bit drive-level code is formed for every column from the latched bit, the frame-inversion input and a blanking input.

Top module: `lcd_col_loader`

## Requirements
- R1: With `wide_bus`=1, every bus word carries 12 data bits on `din[11:0]`, and two words form one 24-bit group. With `wide_bus`=0, only `din[7:0]` carries data, three words form one group, and `din[11:8]` has no effect on the row.
- R2: Bus words and the token input are sampled on the falling edge of `clk`. Within a line, bit k in arrival order is bit k-W·i of the i-th accepted word, where W is 8 or 12.
- R3: While `lpulse` is high, and on the edge where it falls, the loader goes idle. It accepts no word until its active token input is sampled low. Words presented while the token is high leave both the holding register and the next latched row unchanged.
- R4: With `fill_fwd`=1, arrival bit k of the device's share is stored in column k (`row_o[k]`). The token is taken on `tok_a_in_n` and passed on `tok_b_out_n`, and `tok_a_out_n` stays high.
- R5: With `fill_fwd`=0, arrival bit k is stored in `row_o[COLS-1-k]`. The token is taken on `tok_b_in_n` and passed on `tok_a_out_n`, and `tok_b_out_n` stays high.
- R6: After the COLS-th bit is accepted, the active token output is low for exactly the one following clock. All later words are ignored until the next latch pulse, so a second chained device captures arrival bits COLS to 2·COLS-1.
- R7: `row_o` changes only on the falling edge of `lpulse`, and then all columns take the holding register at once.
- R8: With `blank_n`=1, column i has code {`fr`, ~(`row_o[i]` ^ `fr`)}, where 00 selects V0, 01 V2, 10 V3 and 11 V5. A lit pixel gives V0 when `fr`=0 and V5 when `fr`=1. An unlit pixel gives V2 when `fr`=0 and V3 when `fr`=1.
- R9: With `blank_n`=0, every column code is 11 (V5), whatever the row and `fr`.
- R10: After reset, `row_o` is all zero, both token outputs are high and the loader is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, active on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wide_bus | input | 1 | 1 = 12-bit words, 0 = 8-bit words |
| fill_fwd | input | 1 | 1 = fill first to last column, 0 = reverse |
| din | input | 12 | Parallel pixel data word |
| lpulse | input | 1 | Line latch pulse; its falling edge latches the row |
| fr | input | 1 | Frame inversion input |
| blank_n | input | 1 | Low forces every column to V5 |
| tok_a_in_n | input | 1 | Token input used when filling forward |
| tok_b_in_n | input | 1 | Token input used when filling in reverse |
| tok_a_out_n | output | 1 | Token output used when filling in reverse |
| tok_b_out_n | output | 1 | Token output used when filling forward |
| row_o | output | COLS | Latched line data, one bit per column |
| lvl_o | output | 2*COLS | Drive-level code, two bits per column |

## Verification
Two chained loaders receive random lines in all four combinations of bus width and fill direction. This separates a word-packing error (which shows up in one width only) from a column-mapping error (which shows up in one direction only). Each line carries extra words beyond both devices' shares and random junk on the unused upper bus bits in 8-bit mode. The second device's row therefore shows whether the first device stops at exactly its share and hands over the token in the right cycle. A line sent with the token held high must leave the previous row in place after the latch pulse. Level codes are compared over the whole row under both frame polarities and under blanking.

// File: rtl/lcd_col_loader.sv
module lcd_col_loader #(
  parameter int COLS    = 240,
  parameter bit HOLD_EN = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wide_bus,
  input  logic                fill_fwd,
  input  logic [11:0]         din,
  input  logic                lpulse,
  input  logic                fr,
  input  logic                blank_n,
  input  logic                tok_a_in_n,
  input  logic                tok_b_in_n,
  output logic                tok_a_out_n,
  output logic                tok_b_out_n,
  output logic [COLS-1:0]     row_o,
  output logic [2*COLS-1:0]   lvl_o
);
  localparam int GRP  = 24;
  localparam int NGRP = COLS / GRP;
  localparam int NPTR = NGRP / 2;
  localparam int PW   = $clog2(NPTR + 1);
  localparam int GW   = $clog2(NGRP + 1);

  typedef enum logic [1:0] {IDLE, RUN, DONE} st_t;
  st_t st;

  logic [COLS-1:0] hold;
  logic [15:0]     acc;
  logic [1:0]      wc;
  logic [PW-1:0]   ptr;
  logic            half, lp_q, tok_r_n;
  logic [GRP-1:0]  grp, grp_rev;
  logic [GW-1:0]   gidx, pos;

  wire tok_in_n  = fill_fwd ? tok_a_in_n : tok_b_in_n;
  wire lp_fall   = lp_q & ~lpulse;
  wire last_word = wide_bus ? (wc == 2'd1) : (wc == 2'd2);
  wire accept    = (st == RUN) || (st == IDLE && !tok_in_n);

  assign tok_a_out_n = fill_fwd ? 1'b1 : tok_r_n;
  assign tok_b_out_n = fill_fwd ? tok_r_n : 1'b1;

  assign grp  = wide_bus ? {din, acc[11:0]} : {din[7:0], acc};
  assign gidx = GW'({ptr, half});
  assign pos  = fill_fwd ? gidx : GW'(NGRP - 1) - gidx;

  for (genvar b = 0; b < GRP; b++) begin : g_rev
    assign grp_rev[b] = grp[GRP-1-b];
  end

  for (genvar c = 0; c < COLS; c++) begin : g_lvl
    assign lvl_o[2*c+1 -: 2] = !blank_n ? 2'b11 : {fr, ~(row_o[c] ^ fr)};
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      hold    <= '0;
      row_o   <= '0;
      acc     <= '0;
      wc      <= '0;
      ptr     <= '0;
      half    <= 1'b0;
      lp_q    <= 1'b0;
      tok_r_n <= 1'b1;
    end else begin
      lp_q <= lpulse;
      if (lp_fall) row_o <= hold;
      if (!HOLD_EN) tok_r_n <= 1'b1;
      if (lpulse || lp_fall) begin
        st      <= IDLE;
        wc      <= '0;
        ptr     <= '0;
        half    <= 1'b0;
        tok_r_n <= 1'b1;
      end else if (accept) begin
        st <= RUN;
        if (last_word) begin
          hold[pos*GRP +: GRP] <= fill_fwd ? grp : grp_rev;
          wc   <= '0;
          half <= ~half;
          if (half) begin
            if (ptr == PW'(NPTR - 1)) begin
              ptr     <= '0;
              st      <= DONE;
              tok_r_n <= 1'b0;
            end else begin
              ptr <= ptr + 1'b1;
            end
          end
        end else begin
          if (wide_bus) acc[11:0] <= din;
          else if (wc == 2'd0) acc[7:0] <= din[7:0];
          else acc[15:8] <= din[7:0];
          wc <= wc + 1'b1;
        end
      end
    end
  end

  // R6
  no_overflow_chk: assert property (@(negedge clk) disable iff (!rst_n)
    ptr < PW'(NPTR));

  // R1
  word_cnt_chk: assert property (@(negedge clk) disable iff (!rst_n)
    wc <= 2'd2);

  // R3
  idle_wait_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (st == IDLE && tok_in_n) |=> (st == IDLE));

  // R6
  done_ignore_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (st == DONE && !lpulse) |=> $stable(hold));

  // R7
  row_hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
    !lp_fall |=> $stable(row_o));

  if (!HOLD_EN) begin : g_pulse_chk
    // R6
    tok_pulse_chk: assert property (@(negedge clk) disable iff (!rst_n)
      !tok_r_n |=> tok_r_n);
  end
endmodule

// File: tb/tb_lcd_col_loader.sv
module tb_lcd_col_loader;
  localparam int COLS = 240;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wide_bus = 1'b0, fill_fwd = 1'b1, lpulse = 1'b0, fr = 1'b0, blank_n = 1'b0;
  logic tb_tok_n = 1'b1;
  logic [11:0] din = '0;

  logic d1_a_out_n, d1_b_out_n, d2_a_out_n, d2_b_out_n;
  logic [COLS-1:0] row1, row2;
  logic [2*COLS-1:0] lvl1, lvl2;

  int checks = 0, fails = 0;
  logic [2*COLS-1:0] expq[$];
  logic [2*COLS-1:0] last_exp = '0;
  event lat_ev;

  always #2.5 clk = ~clk;

  lcd_col_loader #(.COLS(COLS)) dut (
    .clk(clk), .rst_n(rst_n), .wide_bus(wide_bus), .fill_fwd(fill_fwd), .din(din),
    .lpulse(lpulse), .fr(fr), .blank_n(blank_n),
    .tok_a_in_n(fill_fwd ? tb_tok_n : 1'b1), .tok_b_in_n(fill_fwd ? 1'b1 : tb_tok_n),
    .tok_a_out_n(d1_a_out_n), .tok_b_out_n(d1_b_out_n), .row_o(row1), .lvl_o(lvl1));

  lcd_col_loader #(.COLS(COLS)) dut2 (
    .clk(clk), .rst_n(rst_n), .wide_bus(wide_bus), .fill_fwd(fill_fwd), .din(din),
    .lpulse(lpulse), .fr(fr), .blank_n(blank_n),
    .tok_a_in_n(fill_fwd ? d1_b_out_n : 1'b1), .tok_b_in_n(fill_fwd ? 1'b1 : d1_a_out_n),
    .tok_a_out_n(d2_a_out_n), .tok_b_out_n(d2_b_out_n), .row_o(row2), .lvl_o(lvl2));

  task automatic chk(input bit ok, input string tag, input logic [2*COLS-1:0] act,
                     input logic [2*COLS-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2*COLS-1:0] lvl_exp(input logic [COLS-1:0] r, input logic f,
                                                input logic bn);
    logic [2*COLS-1:0] v;
    for (int c = 0; c < COLS; c++) v[2*c+1 -: 2] = !bn ? 2'b11 : {f, ~(r[c] ^ f)};
    return v;
  endfunction

  task automatic pulse_lp();
    @(posedge clk); lpulse = 1'b1; tb_tok_n = 1'b1;
    @(posedge clk); lpulse = 1'b0;
    -> lat_ev;
    @(posedge clk);
  endtask

  task automatic drive_line(input logic w, input logic fwd, input logic en);
    int wbits = w ? 12 : 8;
    int gw = w ? 2 : 3;
    int nw = 20 * gw + 3;
    logic [2*COLS-1:0] bits;
    logic [COLS-1:0] e1, e2;
    logic tok1, tok2;
    for (int k = 0; k < 2*COLS; k++) bits[k] = 1'($urandom);
    for (int k = 0; k < COLS; k++) begin
      e1[fwd ? k : COLS-1-k] = bits[k];
      e2[fwd ? k : COLS-1-k] = bits[COLS+k];
    end
    if (en) expq.push_back({e2, e1});
    else expq.push_back(last_exp);
    for (int i = 0; i <= nw; i++) begin
      @(posedge clk);
      tok1 = fwd ? d1_b_out_n : d1_a_out_n;
      tok2 = fwd ? d2_b_out_n : d2_a_out_n;
      if (en && i-1 == 10*gw-1)
        chk(tok1 == 1'b0, "R6 token out low after share", {479'b0, tok1}, '0);
      if (en && i-1 == 10*gw)
        chk(tok1 == 1'b1, "R6 token out one cycle", {479'b0, tok1}, 480'b1);
      if (en && i-1 == 20*gw-1)
        chk(tok2 == 1'b0, "R6 second device token", {479'b0, tok2}, '0);
      if (!en && i == nw)
        chk(tok1 == 1'b1, "R3 no token without enable", {479'b0, tok1}, 480'b1);
      if (i == 1)
        chk((fwd ? d1_a_out_n : d1_b_out_n) == 1'b1, fwd ? "R4 unused pin high" : "R5 unused pin high",
            {479'b0, (fwd ? d1_a_out_n : d1_b_out_n)}, 480'b1);
      if (i < nw) begin
        tb_tok_n = !en;
        din = 12'($urandom);
        for (int j = 0; j < wbits; j++)
          if (i*wbits + j < 2*COLS) din[j] = bits[i*wbits + j];
      end
    end
  endtask

  task automatic check_levels();
    @(posedge clk); fr = 1'b0;
    @(posedge clk);
    chk(lvl1 == lvl_exp(last_exp[COLS-1:0], 1'b0, 1'b1), "R8 levels fr=0", lvl1,
        lvl_exp(last_exp[COLS-1:0], 1'b0, 1'b1));
    fr = 1'b1;
    @(posedge clk);
    chk(lvl1 == lvl_exp(last_exp[COLS-1:0], 1'b1, 1'b1), "R8 levels fr=1", lvl1,
        lvl_exp(last_exp[COLS-1:0], 1'b1, 1'b1));
    blank_n = 1'b0;
    @(posedge clk);
    chk(&lvl1 && &lvl2, "R9 blank forces V5", lvl1, '1);
    blank_n = 1'b1; fr = 1'b0;
  endtask

  initial begin : monitor
    logic [2*COLS-1:0] e;
    forever begin
      @(lat_ev);
      @(posedge clk);
      if (expq.size() > 0) begin
        e = expq.pop_front();
        chk(row1 == e[COLS-1:0], fill_fwd ? "R1 R2 R4 R7 first row" : "R1 R2 R5 R7 first row",
            {240'b0, row1}, {240'b0, e[COLS-1:0]});
        chk(row2 == e[2*COLS-1:COLS], "R6 chained second row",
            {240'b0, row2}, {240'b0, e[2*COLS-1:COLS]});
        last_exp = e;
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    chk(row1 == '0 && row2 == '0, "R10 reset row", {240'b0, row1}, '0);
    chk(d1_a_out_n && d1_b_out_n, "R10 reset tokens", {478'b0, d1_a_out_n, d1_b_out_n}, 480'd3);
    chk(&lvl1, "R9 R10 reset blank levels", lvl1, '1);
    rst_n = 1'b1;
    @(posedge clk);
    blank_n = 1'b1;
    pulse_lp();
    for (int m = 0; m < 4; m++) begin
      @(posedge clk);
      wide_bus = m[0];
      fill_fwd = !m[1];
      drive_line(m[0], !m[1], 1'b1);
      pulse_lp();
      @(posedge clk);
      check_levels();
    end
    drive_line(wide_bus, fill_fwd, 1'b0);
    pulse_lp();
    @(posedge clk);
    chk(row1 == last_exp[COLS-1:0], "R3 row kept without enable",
        {240'b0, row1}, {240'b0, last_exp[COLS-1:0]});
    repeat (2) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule